// File: doc/BRIEF.md
# Address Source Selector with Return Stack

This block owns the memory address register of a small byte-wide processor. On each cycle the address register either keeps its value, steps forward by one after an instruction byte is fetched, or takes a new value from one of three places: the H/L register pair, a temporary address register, or the top of an on-chip return stack. The temporary register only exists to collect the inline target of jump and call instructions. Every other memory access gets its address from H and L.

Calls and returns do not use a stack in memory. They use a small register file of return addresses, addressed by an up/down pointer. A push stores the program counter presented at the input. A return loads the address register from the top entry and pops it. The two highest address bits choose one of four memory cards, and the block drives that choice as a one-hot select.

Top module: `addr_src_sel`

## Requirements
- R1: While `rstN` is low, and after it is released, `memAddr` is 0, `cardSel` is 4'b0001, the stack pointer is 0, all stack entries are 0, the temporary register is 0, and the next temporary strobe is taken as the low byte.
- R2: When `loadReq` is high and `loadSrc` is 2'd0 (H/L), `memAddr` becomes `{hReg[4:0], lReg}` one cycle later. `hReg[7:5]` has no effect.
- R3: Each `tmpStrobe` pulse writes `tmpByte`. Pulses alternate between the low byte and the high byte, starting with the low byte. The high byte keeps bits [4:0]. With `loadSrc` equal to 2'd1, `memAddr` becomes `{high[4:0], low}`.
- R4: When `incReq` is high and no load takes place, `memAddr` increments by 1 on the next cycle, wrapping from 13'h1FFF to 0.
- R5: A load overrides `incReq` in the same cycle. `loadSrc` 2'd3 performs no load, so `incReq` then acts alone.
- R6: When `pushReq` is high and `popReq` is low, `pcIn` is written at the stack pointer, and the pointer then increments.
- R7: With `loadSrc` 2'd2, `memAddr` takes the entry at pointer−1. When `popReq` is high and `pushReq` is low, the pointer decrements. A return (load from the stack together with a pop) gives last-in, first-out order.
- R8: The 16-entry stack pointer wraps modulo 16 in both directions, with no trap. The 17th push overwrites entry 0.
- R9: When `pushReq` and `popReq` are both high, neither the pointer nor any stack entry changes.
- R10: `cardSel` is one-hot, with bit n set when `memAddr[12:11]` equals n.
- R11: With no load and no increment, `memAddr` holds its value.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous active-low reset |
| pcIn | input | 13 | Program counter value to push |
| hReg | input | 8 | H register contents (high address byte) |
| lReg | input | 8 | L register contents (low address byte) |
| tmpByte | input | 8 | Byte for the temporary address register |
| tmpStrobe | input | 1 | Writes tmpByte (alternates low byte, then high byte) |
| loadReq | input | 1 | Load the address register |
| loadSrc | input | 2 | Load source: 0 H/L, 1 temporary register, 2 stack top, 3 none |
| pushReq | input | 1 | Push pcIn onto the return stack |
| popReq | input | 1 | Pop the return stack |
| incReq | input | 1 | Increment the address register |
| memAddr | output | 13 | Memory address register |
| cardSel | output | 4 | One-hot memory card select |

## Verification
A stack pointer that is off by one, or a stack entry that gets corrupted, does not show at the ports until the next load from the stack. There it appears as a wrong `memAddr` in the cycle right after the return. For that reason the bench pops after every push pattern, including after wrap-around and after a simultaneous push and pop. A byte-phase error in the temporary register shows up only when the temporary source is loaded, as a swapped or shifted address. The address and card select are compared with the model on every clock, so a wrong increment or a wrong choice of source is caught one cycle after it happens.

// File: rtl/addr_src_pkg.sv
package addr_src_pkg;
  typedef enum logic [1:0] {
    SRC_HL   = 2'd0,
    SRC_TMP  = 2'd1,
    SRC_STK  = 2'd2,
    SRC_NONE = 2'd3
  } srcSel_e;

  typedef struct packed {
    logic    loadEn;
    srcSel_e src;
    logic    incEn;
    logic    pushEn;
    logic    popEn;
    logic    tmpLoWr;
    logic    tmpHiWr;
  } strobes_t;
endpackage

// File: rtl/addr_src_ctrl.sv
module addr_src_ctrl
  import addr_src_pkg::*;
(
  input  logic       clk,
  input  logic       rstN,
  input  logic       tmpStrobe,
  input  logic       loadReq,
  input  logic [1:0] loadSrc,
  input  logic       pushReq,
  input  logic       popReq,
  input  logic       incReq,
  output strobes_t   strb
);
  logic hiPhase;
  srcSel_e srcDec;

  assign srcDec = srcSel_e'(loadSrc);

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)          hiPhase <= 1'b0;
    else if (tmpStrobe) hiPhase <= ~hiPhase;
  end

  always_comb begin
    strb.loadEn  = loadReq && (srcDec != SRC_NONE);
    strb.src     = srcDec;
    strb.incEn   = incReq && !strb.loadEn;
    strb.pushEn  = pushReq && !popReq;
    strb.popEn   = popReq && !pushReq;
    strb.tmpLoWr = tmpStrobe && !hiPhase;
    strb.tmpHiWr = tmpStrobe && hiPhase;
  end

  // R3: a low-byte write is followed by the high-byte phase
  assert_tmp_phase_R3: assert property (@(posedge clk) disable iff (!rstN)
    strb.tmpLoWr |=> hiPhase);
  assert_tmp_back_R3: assert property (@(posedge clk) disable iff (!rstN)
    strb.tmpHiWr |=> !hiPhase);
  // R9: conflicting requests produce no stack strobe
  assert_no_dual_R9: assert property (@(posedge clk) disable iff (!rstN)
    !(strb.pushEn && strb.popEn));
endmodule

// File: rtl/addr_src_dp.sv
module addr_src_dp
  import addr_src_pkg::*;
#(
  parameter int ADDR_W    = 13,
  parameter int BYTE_W    = 8,
  parameter int STK_DEPTH = 16,
  parameter int CARDS     = 4
) (
  input  logic              clk,
  input  logic              rstN,
  input  strobes_t          strb,
  input  logic [ADDR_W-1:0] pcIn,
  input  logic [BYTE_W-1:0] hReg,
  input  logic [BYTE_W-1:0] lReg,
  input  logic [BYTE_W-1:0] tmpByte,
  output logic [ADDR_W-1:0] memAddr,
  output logic [CARDS-1:0]  cardSel
);
  localparam int PTR_W  = $clog2(STK_DEPTH);
  localparam int CARD_W = $clog2(CARDS);
  localparam int HI_W   = ADDR_W - BYTE_W;

  logic [ADDR_W-1:0] stk [STK_DEPTH];
  logic [PTR_W-1:0]  ptr, topIdx;
  logic [BYTE_W-1:0] tmpLo;
  logic [HI_W-1:0]   tmpHi;
  logic [ADDR_W-1:0] hlAddr, tmpAddr, nextAddr;

  assign hlAddr  = {hReg[HI_W-1:0], lReg};
  assign tmpAddr = {tmpHi, tmpLo};
  assign topIdx  = ptr - PTR_W'(1);

  always_comb begin
    nextAddr = memAddr;
    if (strb.loadEn) begin
      case (strb.src)
        SRC_HL:  nextAddr = hlAddr;
        SRC_TMP: nextAddr = tmpAddr;
        SRC_STK: nextAddr = stk[topIdx];
        default: nextAddr = memAddr;
      endcase
    end else if (strb.incEn) begin
      nextAddr = memAddr + ADDR_W'(1);
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      memAddr <= '0;
      tmpLo   <= '0;
      tmpHi   <= '0;
    end else begin
      memAddr <= nextAddr;
      if (strb.tmpLoWr) tmpLo <= tmpByte;
      if (strb.tmpHiWr) tmpHi <= tmpByte[HI_W-1:0];
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      ptr <= '0;
      for (int i = 0; i < STK_DEPTH; i++) stk[i] <= '0;
    end else if (strb.pushEn) begin
      stk[ptr] <= pcIn;
      ptr      <= ptr + PTR_W'(1);
    end else if (strb.popEn) begin
      ptr      <= topIdx;
    end
  end

  for (genvar g = 0; g < CARDS; g++) begin : gCard
    assign cardSel[g] = (memAddr[ADDR_W-1 -: CARD_W] == CARD_W'(g));
  end

  assert_hl_load_R2: assert property (@(posedge clk) disable iff (!rstN)
    (strb.loadEn && strb.src == SRC_HL) |=> memAddr == $past(hlAddr));
  assert_inc_R4: assert property (@(posedge clk) disable iff (!rstN)
    strb.incEn |=> memAddr == ADDR_W'($past(memAddr) + ADDR_W'(1)));
  assert_push_ptr_R6: assert property (@(posedge clk) disable iff (!rstN)
    strb.pushEn |=> ptr == PTR_W'($past(ptr) + PTR_W'(1)));
  assert_pop_ptr_R7: assert property (@(posedge clk) disable iff (!rstN)
    strb.popEn |=> ptr == PTR_W'($past(ptr) - PTR_W'(1)));
  assert_ptr_hold_R9: assert property (@(posedge clk) disable iff (!rstN)
    (!strb.pushEn && !strb.popEn) |=> $stable(ptr));
  assert_addr_hold_R11: assert property (@(posedge clk) disable iff (!rstN)
    (!strb.loadEn && !strb.incEn) |=> $stable(memAddr));
endmodule

// File: rtl/addr_src_sel.sv
module addr_src_sel
  import addr_src_pkg::*;
#(
  parameter int ADDR_W    = 13,
  parameter int BYTE_W    = 8,
  parameter int STK_DEPTH = 16,
  parameter int CARDS     = 4
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic [ADDR_W-1:0] pcIn,
  input  logic [BYTE_W-1:0] hReg,
  input  logic [BYTE_W-1:0] lReg,
  input  logic [BYTE_W-1:0] tmpByte,
  input  logic              tmpStrobe,
  input  logic              loadReq,
  input  logic [1:0]        loadSrc,
  input  logic              pushReq,
  input  logic              popReq,
  input  logic              incReq,
  output logic [ADDR_W-1:0] memAddr,
  output logic [CARDS-1:0]  cardSel
);
  strobes_t strb;

  addr_src_ctrl uCtrl (
    .clk(clk), .rstN(rstN), .tmpStrobe(tmpStrobe), .loadReq(loadReq),
    .loadSrc(loadSrc), .pushReq(pushReq), .popReq(popReq), .incReq(incReq),
    .strb(strb)
  );

  addr_src_dp #(
    .ADDR_W(ADDR_W), .BYTE_W(BYTE_W), .STK_DEPTH(STK_DEPTH), .CARDS(CARDS)
  ) uDp (
    .clk(clk), .rstN(rstN), .strb(strb), .pcIn(pcIn), .hReg(hReg),
    .lReg(lReg), .tmpByte(tmpByte), .memAddr(memAddr), .cardSel(cardSel)
  );

  // R10: exactly one card selected at all times out of reset
  assert_card_onehot_R10: assert property (@(posedge clk) disable iff (!rstN)
    $countones(cardSel) == 1);
  // R5: a load wins over an increment
  assert_load_prio_R5: assert property (@(posedge clk) disable iff (!rstN)
    (loadReq && loadSrc == 2'd0 && incReq) |=> memAddr == $past({hReg[4:0], lReg}));
endmodule

// File: tb/tb_addr_src_sel.sv
module tb_addr_src_sel;
  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic [12:0] pcIn = '0;
  logic [7:0]  hReg = '0, lReg = '0, tmpByte = '0;
  logic        tmpStrobe = 0, loadReq = 0, pushReq = 0, popReq = 0, incReq = 0;
  logic [1:0]  loadSrc = 2'd3;
  logic [12:0] memAddr;
  logic [3:0]  cardSel;

  int testsRun = 0, testsFailed = 0;
  string tag = "R1";
  bit done = 0;

  int mAddr = 0, mPtr = 0, mLo = 0, mHi = 0, mPhase = 0;
  int mStk [16];

  always #4 clk = ~clk;

  addr_src_sel dut (
    .clk(clk), .rstN(rstN), .pcIn(pcIn), .hReg(hReg), .lReg(lReg),
    .tmpByte(tmpByte), .tmpStrobe(tmpStrobe), .loadReq(loadReq),
    .loadSrc(loadSrc), .pushReq(pushReq), .popReq(popReq), .incReq(incReq),
    .memAddr(memAddr), .cardSel(cardSel)
  );

  initial for (int i = 0; i < 16; i++) mStk[i] = 0;

  // behavioural reference model
  always @(posedge clk) begin
    if (!rstN) begin
      mAddr = 0; mPtr = 0; mLo = 0; mHi = 0; mPhase = 0;
      for (int i = 0; i < 16; i++) mStk[i] = 0;
    end else begin
      int nAddr;
      nAddr = mAddr;
      if (loadReq && loadSrc == 2'd0)      nAddr = (hReg % 32) * 256 + lReg;
      else if (loadReq && loadSrc == 2'd1) nAddr = mHi * 256 + mLo;
      else if (loadReq && loadSrc == 2'd2) nAddr = mStk[(mPtr + 15) % 16];
      else if (incReq)                     nAddr = (mAddr + 1) % 8192;
      if (tmpStrobe) begin
        if (mPhase == 0) mLo = tmpByte; else mHi = tmpByte % 32;
        mPhase = 1 - mPhase;
      end
      if (pushReq && !popReq) begin
        mStk[mPtr] = pcIn; mPtr = (mPtr + 1) % 16;
      end else if (popReq && !pushReq) begin
        mPtr = (mPtr + 15) % 16;
      end
      mAddr = nAddr;
    end
  end

  always @(negedge clk) begin
    if (rstN && !done) begin
      int expCard;
      expCard = 1 << (mAddr / 2048);
      testsRun++;
      if (memAddr !== 13'(mAddr) || cardSel !== 4'(expCard)) begin
        testsFailed++;
        $display("FAIL %s: memAddr=%h cardSel=%b expected memAddr=%h cardSel=%b",
                 tag, memAddr, cardSel, 13'(mAddr), 4'(expCard));
      end
    end
  end

  task automatic tick();
    @(posedge clk); @(negedge clk); #1;
    tmpStrobe = 0; loadReq = 0; pushReq = 0; popReq = 0; incReq = 0; loadSrc = 2'd3;
  endtask

  task automatic loadHl(input logic [7:0] h, input logic [7:0] l);
    hReg = h; lReg = l; loadReq = 1; loadSrc = 2'd0; tick();
  endtask

  task automatic pushPc(input logic [12:0] v);
    pcIn = v; pushReq = 1; tick();
  endtask

  task automatic doReturn();
    loadReq = 1; loadSrc = 2'd2; popReq = 1; tick();
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rstN = 1;
    tag = "R1"; tick(); tick();

    tag = "R2"; loadHl(8'hFF, 8'h34); loadHl(8'h05, 8'hA6);
    tag = "R10"; loadHl(8'h00, 8'h11); loadHl(8'h08, 8'h22);
    loadHl(8'h10, 8'h33); loadHl(8'h18, 8'h44);

    tag = "R3";
    tmpByte = 8'h78; tmpStrobe = 1; tick();
    tmpByte = 8'hE5; tmpStrobe = 1; tick();
    loadReq = 1; loadSrc = 2'd1; tick();
    tmpByte = 8'h01; tmpStrobe = 1; tick();
    tmpByte = 8'h1A; tmpStrobe = 1; tick();
    loadReq = 1; loadSrc = 2'd1; tick();

    tag = "R4"; loadHl(8'h1F, 8'hFD);
    for (int i = 0; i < 4; i++) begin incReq = 1; tick(); end

    tag = "R11"; tick(); tick();

    tag = "R5";
    hReg = 8'h02; lReg = 8'h10; loadReq = 1; loadSrc = 2'd0; incReq = 1; tick();
    loadReq = 1; loadSrc = 2'd3; incReq = 1; tick();

    tag = "R6"; pushPc(13'h0123); pushPc(13'h0ABC); pushPc(13'h1F00);
    tag = "R7"; doReturn(); doReturn(); doReturn();

    tag = "R9";
    pushPc(13'h0555);
    pcIn = 13'h1111; pushReq = 1; popReq = 1; tick();
    doReturn();

    tag = "R8";
    for (int i = 0; i < 17; i++) pushPc(13'(i * 97 + 5));
    for (int i = 0; i < 17; i++) doReturn();
    doReturn();

    tag = "R1";
    rstN = 0; @(negedge clk); rstN = 1;
    tick();
    loadReq = 1; loadSrc = 2'd2; tick();

    done = 1;
    $display("[TB] %0d tests run, %0d failed", testsRun, testsFailed);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      done = 1;
      testsRun++; testsFailed++;
      $display("FAIL watchdog: run did not finish, expected completion");
      $display("[TB] %0d tests run, %0d failed", testsRun, testsFailed);
      $finish;
    end
  end
endmodule